// File: doc/BRIEF.md
# Infrared Wake Pattern Matcher

This block holds a stored infrared timing pattern and watches the run-length samples coming from an IR sampler. Each sample byte carries a pulse/space flag and a duration counted in sample periods. When the incoming sequence matches the stored pattern over a programmable number of bytes, with no more than a programmable number of mismatching bytes, the block pulses a wake output and latches a status flag.

A host reaches the block through a small register port. Through it the host loads the pattern, sets the compare depth and the tolerance, reads the stored bytes back through an auto-advancing read index, and clears the status flag. A learning mode lets the block capture incoming samples directly into the pattern store. The store can be emptied only while learning mode is active.

Top module: `ir_wake_matcher`

## Requirements
- R1: After reset the control, depth, tolerance and status registers read 0, the stored byte count and read index read 0, and wake_o is low.
- R2: A sample byte uses bit 7 as the pulse flag (1 = pulse, 0 = space) and bits 6..0 as the duration. A received byte agrees with a stored byte when the pulse flags are equal and the durations differ by at most 1. Any other byte counts as one mismatch.
- R3: A write to address 4 appends host_wdata to the pattern store only while control bit 1 (write mode) is set. Otherwise the write is ignored. Bytes are kept in arrival order.
- R4: The store holds at most DEPTH_MAX bytes. Further appends are dropped and the count stays at DEPTH_MAX.
- R5: Reading address 7 returns the number of stored bytes. Addresses 0, 1, 2 and 3 read back control, depth, tolerance and status.
- R6: Reading address 5 returns the stored byte at the read index and advances the index. Address 6 shows the index. After the last stored byte the index wraps to 0, so the next read returns the first byte again.
- R7: Writing address 7 with bit 0 set empties the store and zeroes the read index only while control bit 2 (learning mode) is set. At any other time the write has no effect.
- R8: In learning mode each valid incoming sample is appended to the store and no matching takes place. A host append in the same cycle takes priority.
- R9: Matching is active only when control bit 0 is set, learning mode is off and the depth is non-zero. An attempt starts only on a pulse byte. Space bytes that arrive while no attempt is in progress are ignored.
- R10: Byte k of an attempt is compared with stored byte k. A position at or beyond the stored count is a mismatch. When the depth-th byte arrives with total mismatches no greater than the tolerance, wake_o is high for exactly the next cycle.
- R11: An attempt is abandoned as soon as its mismatch total exceeds the tolerance. The next pulse byte starts a fresh attempt at position 0.
- R12: The status bit (address 3, bit 0) is set in the cycle after each wake pulse. Writing 1 to it clears it, writing 0 leaves it unchanged, and a new wake takes priority over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (advances the read index on address 5) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from host_addr |
| samp_valid | input | 1 | Incoming run-length sample valid |
| samp_byte | input | 8 | Incoming run-length sample |
| wake_o | output | 1 | One-cycle wake pulse on a pattern match |
| wake_status_o | output | 1 | Latched wake status |

## Verification
The bench builds the block with DEPTH_MAX set to 16 in place of the default 64. This lets it fill the store to saturation with a short burst of host writes and check that the count stops at the limit. Pattern tests use a four-byte pattern with depths of 4, 2 and 0. Tolerances of 0 and 1 show where a duration that is off by 2 moves from rejected to accepted. Short sequences also cover a pulse/space flip, a leading space, and an abort followed by a fresh attempt.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_DEPTH = 3'd1,
        A_TOL   = 3'd2,
        A_STAT  = 3'd3,
        A_WDATA = 3'd4,
        A_RDATA = 3'd5,
        A_RIDX  = 3'd6,
        A_COUNT = 3'd7
    } irw_addr_e;

    typedef struct packed {
        logic learn;     // bit 2
        logic wr_mode;   // bit 1
        logic match_en;  // bit 0
    } irw_ctrl_t;

    // one when two run-length bytes disagree: flag differs or duration off by more than tol
    function automatic logic byte_mismatch(input logic [BYTE_W-1:0] a,
                                           input logic [BYTE_W-1:0] b,
                                           input logic [BYTE_W-1:0] tol);
        logic [BYTE_W-1:0] da;
        logic [BYTE_W-1:0] db;
        logic [BYTE_W-1:0] diff;
        da   = {1'b0, a[BYTE_W-2:0]};
        db   = {1'b0, b[BYTE_W-2:0]};
        diff = (da > db) ? (da - db) : (db - da);
        return (a[BYTE_W-1] != b[BYTE_W-1]) || (diff > tol);
    endfunction

endpackage

// File: rtl/irw_store.sv
module irw_store
    import irw_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int AW        = $clog2(DEPTH_MAX),
    parameter int CW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic              clear,
    input  logic              rd_adv,
    input  logic [AW-1:0]     cmp_idx,
    output logic [CW-1:0]     count,
    output logic [AW-1:0]     ridx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] cmp_byte
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH_MAX);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [AW-1:0] ridx;
    } st_t;

    st_t st_d, st_q;
    logic [BYTE_W-1:0] mem_q [DEPTH_MAX];
    logic              do_push;
    logic [CW-1:0]     ridx_inc;

    assign do_push  = push && !clear && (st_q.count < FULL);
    assign ridx_inc = {1'b0, st_q.ridx} + CW'(1);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.count = '0;
            st_d.ridx  = '0;
        end else begin
            if (do_push) st_d.count = st_q.count + CW'(1);
            if (rd_adv && st_q.count != '0)
                st_d.ridx = (ridx_inc >= st_q.count) ? '0 : ridx_inc[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.count[AW-1:0]] <= push_byte;
    end

    assign count    = st_q.count;
    assign ridx     = st_q.ridx;
    assign rd_byte  = mem_q[st_q.ridx];
    assign cmp_byte = mem_q[cmp_idx];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL);                                           // R4
    AST_RIDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count != '0) |-> ({1'b0, st_q.ridx} < st_q.count));      // R6
    AST_RIDX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0) |-> (st_q.ridx == '0));                     // R6
    AST_EMPTY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear == 1'b0 && st_q.count != '0) |=> (st_q.count != '0));   // R7

endmodule

// File: rtl/irw_match.sv
module irw_match
    import irw_pkg::*;
#(
    parameter int CW      = 7,
    parameter int DUR_TOL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              samp_valid,
    input  logic [BYTE_W-1:0] samp_byte,
    input  logic [CW-1:0]     depth,
    input  logic [CW-1:0]     tol,
    input  logic [CW-1:0]     count,
    input  logic [BYTE_W-1:0] pat_byte,
    output logic [CW-1:0]     pat_idx,
    output logic              wake
);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] pos;
        logic [CW:0]   miss;
        logic          wake;
    } mt_t;

    mt_t mt_d, mt_q;
    logic [CW-1:0] cur_pos;
    logic [CW:0]   cur_miss;
    logic          mis;

    always_comb begin
        mt_d      = mt_q;
        mt_d.wake = 1'b0;
        cur_pos   = mt_q.active ? mt_q.pos : '0;
        mis       = (cur_pos >= count) ||
                    byte_mismatch(samp_byte, pat_byte, BYTE_W'(DUR_TOL));
        cur_miss  = (mt_q.active ? mt_q.miss : '0) + {{CW{1'b0}}, mis};
        if (!enable || depth == '0) begin
            mt_d.active = 1'b0;
            mt_d.pos    = '0;
            mt_d.miss   = '0;
        end else if (samp_valid && (mt_q.active || samp_byte[BYTE_W-1])) begin
            if (cur_miss > {1'b0, tol}) begin
                mt_d.active = 1'b0;
                mt_d.pos    = '0;
                mt_d.miss   = '0;
            end else if (cur_pos + CW'(1) == depth) begin
                mt_d.wake   = 1'b1;
                mt_d.active = 1'b0;
                mt_d.pos    = '0;
                mt_d.miss   = '0;
            end else begin
                mt_d.active = 1'b1;
                mt_d.pos    = cur_pos + CW'(1);
                mt_d.miss   = cur_miss;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mt_q <= '0;
        else        mt_q <= mt_d;
    end

    assign pat_idx = cur_pos;
    assign wake    = mt_q.wake;

    AST_WAKE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        mt_q.wake |-> $past(samp_valid));                              // R10
    AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mt_q.wake |-> $past(enable));                                  // R9
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mt_q.active);                                     // R9

endmodule

// File: rtl/ir_wake_matcher.sv
module ir_wake_matcher
    import irw_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int DUR_TOL   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       samp_valid,
    input  logic [7:0] samp_byte,
    output logic       wake_o,
    output logic       wake_status_o
);

    localparam int AW = $clog2(DEPTH_MAX);
    localparam int CW = AW + 1;

    typedef struct packed {
        irw_ctrl_t     ctrl;
        logic [CW-1:0] depth;
        logic [CW-1:0] tol;
        logic          stat;
    } rg_t;

    rg_t rg_d, rg_q;

    logic              host_push, learn_push, push, clear, rd_adv, enable, wake;
    logic [BYTE_W-1:0] push_byte, rd_byte, cmp_byte;
    logic [CW-1:0]     count, pat_idx;
    logic [AW-1:0]     ridx;

    assign host_push  = host_wr && (host_addr == A_WDATA) && rg_q.ctrl.wr_mode;
    assign learn_push = samp_valid && rg_q.ctrl.learn && !host_push;
    assign push       = host_push || learn_push;
    assign push_byte  = host_push ? host_wdata : samp_byte;
    assign clear      = host_wr && (host_addr == A_COUNT) && host_wdata[0] && rg_q.ctrl.learn;
    assign rd_adv     = host_rd && (host_addr == A_RDATA);
    assign enable     = rg_q.ctrl.match_en && !rg_q.ctrl.learn;

    always_comb begin
        rg_d = rg_q;
        if (host_wr) begin
            case (host_addr)
                A_CTRL:  rg_d.ctrl  = irw_ctrl_t'(host_wdata[2:0]);
                A_DEPTH: rg_d.depth = host_wdata[CW-1:0];
                A_TOL:   rg_d.tol   = host_wdata[CW-1:0];
                A_STAT:  if (host_wdata[0]) rg_d.stat = 1'b0;
                default: ;
            endcase
        end
        if (wake) rg_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (host_addr)
            A_CTRL:  host_rdata = {5'd0, rg_q.ctrl};
            A_DEPTH: host_rdata = 8'(rg_q.depth);
            A_TOL:   host_rdata = 8'(rg_q.tol);
            A_STAT:  host_rdata = {7'd0, rg_q.stat};
            A_RDATA: host_rdata = rd_byte;
            A_RIDX:  host_rdata = 8'(ridx);
            A_COUNT: host_rdata = 8'(count);
            default: host_rdata = 8'd0;
        endcase
    end

    irw_store #(.DEPTH_MAX(DEPTH_MAX), .AW(AW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_byte(push_byte),
        .clear(clear), .rd_adv(rd_adv), .cmp_idx(pat_idx[AW-1:0]),
        .count(count), .ridx(ridx), .rd_byte(rd_byte), .cmp_byte(cmp_byte)
    );

    irw_match #(.CW(CW), .DUR_TOL(DUR_TOL)) u_match (
        .clk(clk), .rst_n(rst_n), .enable(enable), .samp_valid(samp_valid),
        .samp_byte(samp_byte), .depth(rg_q.depth), .tol(rg_q.tol),
        .count(count), .pat_byte(cmp_byte), .pat_idx(pat_idx), .wake(wake)
    );

    assign wake_o        = wake;
    assign wake_status_o = rg_q.stat;

    AST_WAKE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> rg_q.stat);                                           // R12
    AST_CLEAR_IN_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && $past(count) != '0) |-> $past(rg_q.ctrl.learn)); // R7
    AST_NO_WAKE_LEARNING: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !$past(rg_q.ctrl.learn));                             // R8
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_WDATA && !rg_q.ctrl.wr_mode && !learn_push)
        |=> $stable(count));                                           // R3

endmodule

// File: tb/sim_ir_wake_matcher.sv
module sim_ir_wake_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       samp_valid = 1'b0;
    logic [7:0] samp_byte = 8'd0;
    logic       wake_o, wake_status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ir_wake_matcher #(.DEPTH_MAX(16), .DUR_TOL(1)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .samp_valid(samp_valid), .samp_byte(samp_byte),
        .wake_o(wake_o), .wake_status_o(wake_status_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic samp(input logic [7:0] b);
        samp_valid = 1'b1; samp_byte = b;
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    // send four bytes, then check wake in the following cycle and its drop
    task automatic send4(input string req, input logic [7:0] b0, b1, b2, b3, input logic exp);
        samp(b0); samp(b1); samp(b2); samp(b3);
        chk(req, wake_o, exp);
        @(negedge clk);
        chk(req, wake_o, 1'b0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(3'd0, v); chk("R1 ctrl", v, 8'd0);
        peek(3'd1, v); chk("R1 depth", v, 8'd0);
        peek(3'd3, v); chk("R1 status", v, 8'd0);
        peek(3'd7, v); chk("R1 count", v, 8'd0);
        peek(3'd6, v); chk("R1 ridx", v, 8'd0);
        chk("R1 wake", wake_o, 1'b0);
    endtask

    task automatic t_load;
        logic [7:0] v;
        wr(3'd4, 8'h8A);
        peek(3'd7, v); chk("R3 locked write ignored", v, 8'd0);
        wr(3'd0, 8'h02);
        wr(3'd4, 8'h8A); wr(3'd4, 8'h05); wr(3'd4, 8'h8A); wr(3'd4, 8'h14);
        peek(3'd7, v); chk("R5 count after four", v, 8'd4);
        peek(3'd0, v); chk("R5 ctrl readback", v, 8'd2);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        rd(3'd5, v); chk("R6 byte0", v, 8'h8A);
        peek(3'd6, v); chk("R6 index1", v, 8'd1);
        rd(3'd5, v); chk("R6 byte1", v, 8'h05);
        rd(3'd5, v); chk("R6 byte2", v, 8'h8A);
        rd(3'd5, v); chk("R6 byte3", v, 8'h14);
        peek(3'd6, v); chk("R6 index wrapped", v, 8'd0);
        rd(3'd5, v); chk("R6 first again", v, 8'h8A);
        rd(3'd5, v); rd(3'd5, v); rd(3'd5, v);
    endtask

    task automatic t_clear_locked;
        logic [7:0] v;
        wr(3'd7, 8'h01);
        peek(3'd7, v); chk("R7 clear ignored outside learning", v, 8'd4);
    endtask

    task automatic t_match;
        logic [7:0] v;
        wr(3'd0, 8'h01); wr(3'd1, 8'd4); wr(3'd2, 8'd0);
        send4("R10 exact match", 8'h8A, 8'h05, 8'h8A, 8'h14, 1'b1);
        chk("R12 status set", wake_status_o, 1'b1);
        send4("R2 within one period", 8'h8B, 8'h04, 8'h89, 8'h15, 1'b1);
        send4("R2 off by two rejected", 8'h8C, 8'h05, 8'h8A, 8'h14, 1'b0);
        wr(3'd2, 8'd1);
        send4("R10 tolerance of one accepts", 8'h8C, 8'h05, 8'h8A, 8'h14, 1'b1);
        wr(3'd2, 8'd0);
        samp(8'h8A); samp(8'h85);
        chk("R2 flag flip rejected", wake_o, 1'b0);
        samp(8'h05);
        send4("R9 leading space ignored", 8'h8A, 8'h05, 8'h8A, 8'h14, 1'b1);
        samp(8'h90);
        send4("R11 restart after abort", 8'h8A, 8'h05, 8'h8A, 8'h14, 1'b1);
        wr(3'd1, 8'd2);
        samp(8'h8A); samp(8'h05);
        chk("R10 depth two", wake_o, 1'b1);
        wr(3'd1, 8'd0);
        send4("R9 depth zero never wakes", 8'h8A, 8'h05, 8'h8A, 8'h14, 1'b0);
        wr(3'd1, 8'd4); wr(3'd0, 8'h00);
        send4("R9 disabled", 8'h8A, 8'h05, 8'h8A, 8'h14, 1'b0);
        wr(3'd3, 8'h00);
        peek(3'd3, v); chk("R12 write zero keeps", v, 8'd1);
        wr(3'd3, 8'h01);
        peek(3'd3, v); chk("R12 write one clears", v, 8'd0);
    endtask

    task automatic t_learn;
        logic [7:0] v;
        wr(3'd0, 8'h05);
        wr(3'd7, 8'h01);
        peek(3'd7, v); chk("R7 clear in learning", v, 8'd0);
        peek(3'd6, v); chk("R7 index cleared", v, 8'd0);
        send4("R8 no wake while learning", 8'h83, 8'h02, 8'h84, 8'h03, 1'b0);
        peek(3'd7, v); chk("R8 learned count", v, 8'd4);
        rd(3'd5, v); chk("R8 learned byte0", v, 8'h83);
        rd(3'd5, v); chk("R8 learned byte1", v, 8'h02);
    endtask

    task automatic t_full;
        logic [7:0] v;
        wr(3'd0, 8'h04); wr(3'd7, 8'h01);
        wr(3'd0, 8'h02);
        for (int i = 0; i < 18; i++) wr(3'd4, 8'(i + 1));
        peek(3'd7, v); chk("R4 saturates", v, 8'd16);
        for (int i = 0; i < 15; i++) rd(3'd5, v);
        rd(3'd5, v); chk("R4 last kept byte", v, 8'd16);
        rd(3'd5, v); chk("R4 wrap to first", v, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_readback();
        t_clear_locked();
        t_match();
        t_learn();
        t_full();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule